// File: doc/BRIEF.md
# Upper-Memory Bank Switch Controller

This block decides, for every processor access to the top 12 KB of a 16-bit address space (D000–FFFF), whether the data comes from ROM or RAM and whether a write may reach RAM. The lowest 4 KB of that window (D000–DFFF) is banked: it shows one of two 4 KB RAM banks. The upper 8 KB (E000–FFFF) has a single RAM bank. Read source and write permission are chosen independently, so software can read ROM while it copies the same data into the RAM underneath.

Software changes the configuration by touching any address in the 16-byte switch page C080–C08F, with either a read or a write. The three meaningful address bits of that access are latched into a 4-bit state register. That register drives the routing outputs, a physical RAM offset (bank 1 is moved down to C000–CFFF of the RAM array), the main/auxiliary RAM select taken from the alternate-zero-page flag, and two status bytes that software can read.

Top module: `lcard_bank_ctrl`

## Requirements
- R1: A valid access (read or write) whose address lies in C080–C08F loads the state with the address's low nibble ANDed with 0xB. State bit 2 is therefore always 0. Any other access, including C07F and C090, leaves the state unchanged.
- R2: After reset the state is 0x2, so window reads come from ROM and RAM writes are blocked.
- R3: The read source follows state bits [1:0]. 00 and 11 read RAM (`rd_ram`=1). 01 and 10 read ROM (`rd_rom`=1). The same rule covers D000–DFFF and E000–FFFF, and `rd_ram` and `rd_rom` are never both high.
- R4: A window write asserts `ram_we` only when state bit 0 is 1 (modes 01 and 11). In modes 00 and 10, `ram_we` stays low across the whole D000–FFFF range.
- R5: For a valid window access, `ram_addr` carries the physical RAM offset. In D000–DFFF with state bit 3 = 0 (bank 2) it equals the address. With bit 3 = 1 (bank 1) it is C000 plus the low 12 address bits. In E000–FFFF it always equals the address.
- R6: `ram_aux` equals `alt_zp` when the access reaches RAM (`rd_ram` or `ram_we` high), and is 0 otherwise.
- R7: `bank2_stat` is 0x80 when the state value is below 4 (bit 3 clear), and 0x00 otherwise.
- R8: `ramrd_stat` is 0x00 when state bits 0 and 1 differ (ROM read), and 0x80 when they are equal.
- R9: An access outside D000–FFFF, or no valid access at all, keeps `rd_ram`, `rd_rom`, `ram_we` and `ram_aux` low, and drives `ram_addr` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | A processor access is present this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Access address |
| alt_zp | input | 1 | Alternate-zero-page flag: 1 selects auxiliary RAM |
| rd_ram | output | 1 | Read data comes from RAM |
| rd_rom | output | 1 | Read data comes from ROM |
| ram_we | output | 1 | Write enable for RAM |
| ram_aux | output | 1 | RAM access goes to auxiliary RAM |
| ram_addr | output | ADDR_W | Physical RAM offset |
| bank_state | output | 4 | Current bank state register |
| bank2_stat | output | DATA_W | Bank-2 status byte |
| ramrd_stat | output | DATA_W | RAM-read status byte |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 8-bit status bytes, the switch page at C080, the window starting at D000 with a 4 KB banked part, and bank 1 relocated to C000. These values let the bench walk all sixteen switch-page addresses, each with both flag settings. They also place the edges of the banked part (D000, DFFF, E000, FFFF) and the addresses just outside the switch page where directed probes can reach them. Every probe is checked against the mode table worked out from the requirements.

// File: rtl/lcb_pkg.sv
package lcb_pkg;

  localparam int unsigned LC_STATE_W = 4;
  localparam logic [LC_STATE_W-1:0] LC_STATE_MASK  = 4'hB;
  localparam logic [LC_STATE_W-1:0] LC_STATE_RESET = 4'h2;

  // Low two state bits: read source and write permission together
  typedef enum logic [1:0] {
    MD_RAM_NOWR = 2'b00,
    MD_ROM_WR   = 2'b01,
    MD_ROM_NOWR = 2'b10,
    MD_RAM_WR   = 2'b11
  } lc_mode_e;

  function automatic logic mode_reads_ram(input lc_mode_e m);
    return (m == MD_RAM_NOWR) || (m == MD_RAM_WR);
  endfunction

  function automatic logic mode_allows_write(input lc_mode_e m);
    return (m == MD_ROM_WR) || (m == MD_RAM_WR);
  endfunction

endpackage

// File: rtl/lcb_rst_sync.sv
module lcb_rst_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [SYNC_STAGES-1:0] sh_q;
  logic [SYNC_STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[SYNC_STAGES-1];

  initial begin
    p_stage_count_r2: assert (SYNC_STAGES >= 2)
      else $error("reset synchronizer needs at least two stages");
  end
endmodule

// File: rtl/lcb_switch_reg.sv
module lcb_switch_reg
  import lcb_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SW_BASE = 16'hC080
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid,
  input  logic [ADDR_W-1:0]     acc_addr,
  output logic [LC_STATE_W-1:0] state_q
);
  localparam int unsigned PAGE_LSB = LC_STATE_W;

  logic                  sw_hit;
  logic                  load_en;
  logic [LC_STATE_W-1:0] state_d;

  always_comb begin
    sw_hit  = (acc_addr[ADDR_W-1:PAGE_LSB] == SW_BASE[ADDR_W-1:PAGE_LSB]);
    load_en = acc_valid && sw_hit;
    state_d = acc_addr[LC_STATE_W-1:0] & LC_STATE_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= LC_STATE_RESET;
    else if (load_en) state_q <= state_d;
  end

  // R1: a switch-page access lands in the register one cycle later
  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && sw_hit) |=> (state_q == ($past(acc_addr[LC_STATE_W-1:0]) & LC_STATE_MASK)));
  // R1: any other access leaves the state alone
  p_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && sw_hit) |=> $stable(state_q));
  // R1: the masked-off bit never appears
  p_bit2_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state_q[2] == 1'b0);
endmodule

// File: rtl/lcb_window_decode.sv
module lcb_window_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hD000,
  parameter int unsigned BANK_LOG2 = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win,
  output logic              in_banked
);
  localparam logic [ADDR_W:0] BANK_END =
    {1'b0, WIN_BASE} + (ADDR_W+1)'(1 << BANK_LOG2);

  always_comb begin
    in_win    = (addr >= WIN_BASE);
    in_banked = in_win && ({1'b0, addr} < BANK_END);
  end
endmodule

// File: rtl/lcb_route.sv
module lcb_route
  import lcb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BANK_LOG2 = 12,
  parameter logic [ADDR_W-1:0] BANK1_BASE = 16'hC000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              in_win,
  input  logic              in_banked,
  input  logic              alt_zp,
  input  logic              bank1_sel,
  input  lc_mode_e          mode,
  output logic              rd_ram,
  output logic              rd_rom,
  output logic              ram_we,
  output logic              ram_aux,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] bank2_stat,
  output logic [DATA_W-1:0] ramrd_stat
);
  logic win_acc;
  logic ram_src;

  always_comb begin
    win_acc = acc_valid && in_win;
    ram_src = mode_reads_ram(mode);
    rd_ram  = win_acc && !acc_wr && ram_src;
    rd_rom  = win_acc && !acc_wr && !ram_src;
    ram_we  = win_acc && acc_wr && mode_allows_write(mode);
    ram_aux = alt_zp && (rd_ram || ram_we);
    if (!win_acc)
      ram_addr = '0;
    else if (in_banked && bank1_sel)
      ram_addr = {BANK1_BASE[ADDR_W-1:BANK_LOG2], acc_addr[BANK_LOG2-1:0]};
    else
      ram_addr = acc_addr;
  end

  // Status bytes: the flag sits in the top bit only
  for (genvar i = 0; i < DATA_W; i++) begin : g_stat
    if (i == DATA_W-1) begin : g_flag
      assign bank2_stat[i] = !bank1_sel;
      assign ramrd_stat[i] = ram_src;
    end else begin : g_zero
      assign bank2_stat[i] = 1'b0;
      assign ramrd_stat[i] = 1'b0;
    end
  end

  // R3: never two read sources
  p_one_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_ram, rd_rom}));
  // R4: write-protected modes keep the enable low
  p_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MD_RAM_NOWR) || (mode == MD_ROM_NOWR)) |-> !ram_we);
  // R5: bank 1 lands in the relocated block
  p_bank1_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_banked && bank1_sel && (rd_ram || ram_we)) |->
      (ram_addr[ADDR_W-1:BANK_LOG2] == BANK1_BASE[ADDR_W-1:BANK_LOG2]));
  // R6: auxiliary select only on a RAM access
  p_aux_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_ram || ram_we) |-> !ram_aux);
  // R9: nothing leaves the block for an address outside the window
  p_outside_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |-> !(rd_ram || rd_rom || ram_we || ram_aux));
endmodule

// File: rtl/lcard_bank_ctrl.sv
module lcard_bank_ctrl
  import lcb_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned BANK_LOG2   = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] SW_BASE    = 16'hC080,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 16'hD000,
  parameter logic [ADDR_W-1:0] BANK1_BASE = 16'hC000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid,
  input  logic                  acc_wr,
  input  logic [ADDR_W-1:0]     acc_addr,
  input  logic                  alt_zp,
  output logic                  rd_ram,
  output logic                  rd_rom,
  output logic                  ram_we,
  output logic                  ram_aux,
  output logic [ADDR_W-1:0]     ram_addr,
  output logic [LC_STATE_W-1:0] bank_state,
  output logic [DATA_W-1:0]     bank2_stat,
  output logic [DATA_W-1:0]     ramrd_stat
);
  logic     rst_sync_n;
  logic     in_win;
  logic     in_banked;
  lc_mode_e mode;

  lcb_rst_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lcb_switch_reg #(.ADDR_W(ADDR_W), .SW_BASE(SW_BASE)) u_reg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .state_q   (bank_state)
  );

  lcb_window_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .BANK_LOG2(BANK_LOG2)) u_dec (
    .addr      (acc_addr),
    .in_win    (in_win),
    .in_banked (in_banked)
  );

  assign mode = lc_mode_e'(bank_state[1:0]);

  lcb_route #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_LOG2(BANK_LOG2), .BANK1_BASE(BANK1_BASE)
  ) u_route (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .acc_valid  (acc_valid),
    .acc_wr     (acc_wr),
    .acc_addr   (acc_addr),
    .in_win     (in_win),
    .in_banked  (in_banked),
    .alt_zp     (alt_zp),
    .bank1_sel  (bank_state[3]),
    .mode       (mode),
    .rd_ram     (rd_ram),
    .rd_rom     (rd_rom),
    .ram_we     (ram_we),
    .ram_aux    (ram_aux),
    .ram_addr   (ram_addr),
    .bank2_stat (bank2_stat),
    .ramrd_stat (ramrd_stat)
  );
endmodule

// File: tb/tb_lcard_bank_ctrl.sv
module tb_lcard_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_wr = 1'b0;
  logic [15:0] acc_addr = 16'h0000;
  logic        alt_zp = 1'b0;
  logic        rd_ram, rd_rom, ram_we, ram_aux;
  logic [15:0] ram_addr;
  logic [3:0]  bank_state;
  logic [7:0]  bank2_stat, ramrd_stat;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  lcard_bank_ctrl dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .alt_zp(alt_zp), .rd_ram(rd_ram), .rd_rom(rd_rom),
    .ram_we(ram_we), .ram_aux(ram_aux), .ram_addr(ram_addr),
    .bank_state(bank_state), .bank2_stat(bank2_stat), .ramrd_stat(ramrd_stat)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Switch-page touch: state loads at the next rising edge
  task automatic touch(input logic [15:0] a, input logic wr);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_wr = wr;
    @(posedge clk); #1;
    acc_valid = 1'b0;
  endtask

  // Drive a window access and sample the combinational outputs
  task automatic probe(input logic [15:0] a, input logic wr, input logic az);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_wr = wr; alt_zp = az;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    idle();
    check("R2", "reset state", bank_state, 4'h2);
    check("R7", "bank2 after reset", bank2_stat, 8'h80);
    check("R8", "ramrd after reset", ramrd_stat, 8'h00);
    probe(16'hD123, 1'b0, 1'b0);
    check("R2", "reset read from rom", {rd_ram, rd_rom}, 2'b01);
    probe(16'hF000, 1'b1, 1'b0);
    check("R2", "reset write blocked", ram_we, 1'b0);
  endtask

  task automatic t_all_states();
    for (int n = 0; n < 16; n++) begin
      logic [3:0] st;
      logic ramsrc, wok;
      st = 4'(n) & 4'hB;
      ramsrc = (st[1:0] == 2'b00) || (st[1:0] == 2'b11);
      wok = (st[1:0] == 2'b01) || (st[1:0] == 2'b11);
      touch(16'hC080 | 16'(n), n[0]);
      idle();
      check("R1", "state load", bank_state, st);
      check("R7", "bank2 status", bank2_stat, st[3] ? 8'h00 : 8'h80);
      check("R8", "ramrd status", ramrd_stat, ramsrc ? 8'h80 : 8'h00);
      for (int az = 0; az < 2; az++) begin
        probe(16'hD456, 1'b0, az[0]);
        check("R3", "banked read src", {rd_ram, rd_rom}, {ramsrc, !ramsrc});
        check("R5", "banked offset", ram_addr, st[3] ? 16'hC456 : 16'hD456);
        check("R6", "banked aux", ram_aux, ramsrc & az[0]);
        probe(16'hE789, 1'b0, az[0]);
        check("R3", "upper read src", {rd_ram, rd_rom}, {ramsrc, !ramsrc});
        probe(16'hD9AB, 1'b1, az[0]);
        check("R4", "banked write en", ram_we, wok);
        check("R6", "write aux", ram_aux, wok & az[0]);
        probe(16'hE789, 1'b1, az[0]);
        check("R4", "upper write en", ram_we, wok);
        check("R5", "upper offset", ram_addr, 16'hE789);
      end
    end
  endtask

  task automatic t_ignore();
    touch(16'hC08B, 1'b0);                    // bank 1, RAM read/write
    touch(16'hC07F, 1'b1);
    touch(16'hC090, 1'b0);
    touch(16'hD082, 1'b1);
    idle();
    check("R1", "neighbours ignored", bank_state, 4'hB);
    probe(16'hD010, 1'b0, 1'b0);
    check("R1", "routing unchanged", {rd_ram, rd_rom}, 2'b10);
    touch(16'hC08F, 1'b1);
    idle();
    check("R1", "top of page loads", bank_state, 4'hB);
    touch(16'hC084, 1'b0);
    idle();
    check("R1", "bit2 dropped", bank_state, 4'h0);
  endtask

  task automatic t_edges();
    touch(16'hC08B, 1'b1);                    // bank 1, RAM read/write
    probe(16'hD000, 1'b0, 1'b0);
    check("R5", "bank1 low edge", ram_addr, 16'hC000);
    probe(16'hDFFF, 1'b1, 1'b0);
    check("R5", "bank1 high edge", ram_addr, 16'hCFFF);
    probe(16'hE000, 1'b0, 1'b0);
    check("R5", "upper low edge", ram_addr, 16'hE000);
    probe(16'hFFFF, 1'b1, 1'b1);
    check("R5", "upper top", ram_addr, 16'hFFFF);
    check("R6", "upper aux", ram_aux, 1'b1);
    touch(16'hC083, 1'b0);                    // bank 2, RAM read/write
    probe(16'hDFFF, 1'b0, 1'b0);
    check("R5", "bank2 high edge", ram_addr, 16'hDFFF);
  endtask

  task automatic t_outside();
    touch(16'hC083, 1'b0);
    probe(16'hCFFF, 1'b0, 1'b1);
    check("R9", "below window read", {rd_ram, rd_rom, ram_we, ram_aux}, 4'b0000);
    check("R9", "below window addr", ram_addr, 16'h0000);
    probe(16'h1234, 1'b1, 1'b1);
    check("R9", "low write", {rd_ram, rd_rom, ram_we, ram_aux}, 4'b0000);
    probe(16'hE000, 1'b1, 1'b1);
    acc_valid = 1'b0; #1;
    check("R9", "no valid", {rd_ram, rd_rom, ram_we, ram_aux}, 4'b0000);
    check("R9", "no valid addr", ram_addr, 16'h0000);
  endtask

  initial begin
    #(200000 * 10);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_all_states();
    t_ignore();
    t_edges();
    t_outside();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule